// File: doc/BRIEF.md
# Load-Use Stall Unit for a Five-Stage Pipeline

This block spots the one data dependency in a five-stage in-order pipeline that forwarding cannot cover: a memory load sits in the execute stage while the very next instruction, now in decode, names the loaded register as one of its sources. In that case the unit holds the program counter and the fetch/decode register for one cycle, so the consumer is decoded again. It also sends a no-op into execute by zeroing every control field bound for the decode/execute register. One cycle later the load has reached the memory stage, and the normal forwarding path from the memory/writeback register can supply the value.

The check uses the memory-read flag and destination register held in the decode/execute register, and both source register numbers held in the fetch/decode register. Register zero is never a real producer, so a load into it causes no stall. The block also carries a small register-level pipeline (fetch/decode, decode/execute, execute/memory, memory/writeback) that moves only the control and register-number fields. This lets the bench feed instruction sequences in and see where bubbles land and when each instruction retires.

Top module: `lu_hazard_unit`

## Requirements
- R1: `hazard` is 1 when the execute stage holds a valid load (`ex_mem_rd`=1), its nonzero destination equals source A or source B of a valid instruction in the fetch/decode register.
- R2: A load whose destination is register 0 never raises `hazard`, whatever the consumer's sources are.
- R3: `hazard` stays 0 in these cases: the execute-stage instruction is not a load, the fetch/decode slot is empty, or no source matches. Two back-to-back independent loads and a use two instructions after the load therefore cause no stall.
- R4: `pc_we` and `fd_we` are 0 in exactly the cycles where `hazard` is 1 and 1 in all other cycles. While they are 0, the fetch/decode register keeps its contents.
- R5: `ctl_bubble` is 1 in exactly the hazard cycles. In the following cycle the execute-stage outputs `ex_valid`, `ex_mem_rd` and `ex_reg_wr` are all 0.
- R6: Each adjacent load/consumer pair costs exactly one stall cycle: `hazard` is never 1 in two consecutive cycles.
- R7: During and just after reset, `pc_we`=1, `fd_we`=1, `ctl_bubble`=0, `hazard`=0, and the execute and writeback stages are empty.
- R8: Each instruction presented while `pc_we`=1 reaches writeback (`wb_valid`=1) exactly once, in program order, with its destination on `wb_dst`. For n instructions with S stalls, first presented in cycle 0, the last one retires in cycle n+S+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | Fetch slot holds an instruction |
| if_mem_rd | input | 1 | Fetched instruction is a load |
| if_reg_wr | input | 1 | Fetched instruction writes a register |
| if_dst | input | REG_W | Destination register number of the fetched instruction |
| if_src_a | input | REG_W | First source register number |
| if_src_b | input | REG_W | Second source register number |
| pc_we | output | 1 | Program counter may advance |
| fd_we | output | 1 | Fetch/decode register may load |
| ctl_bubble | output | 1 | Zero the control fields entering decode/execute |
| hazard | output | 1 | Load-use conflict detected this cycle |
| ex_valid | output | 1 | Execute stage holds an instruction |
| ex_mem_rd | output | 1 | Execute-stage instruction is a load |
| ex_reg_wr | output | 1 | Execute-stage instruction writes a register |
| ex_dst | output | REG_W | Execute-stage destination |
| wb_valid | output | 1 | Writeback stage holds an instruction (retire) |
| wb_mem_rd | output | 1 | Retiring instruction is a load |
| wb_reg_wr | output | 1 | Retiring instruction writes a register |
| wb_dst | output | REG_W | Retiring instruction's destination |

## Verification
Directed sequences separate the match on source A from the match on source B. They also show that a load into register 0 is harmless, and that two independent loads or a consumer placed two slots after the load cost nothing. A load feeding a load's address, which in turn feeds an arithmetic use, must stall twice and never merge the two stalls. Random sequences over only four register numbers make matches, misses and zero-register loads frequent and mixed. For every run, the bench works out from the program alone the cycle in which each stall must occur, the position of the bubble one cycle later, the retire order and the final cycle count.

// File: rtl/lu_pkg.sv
package lu_pkg;

  // Number of source operands compared against the load target.
  localparam int LU_NUM_SRC = 2;

  // Number of pipeline registers after decode/execute (ex/mem, mem/wb).
  localparam int LU_TAIL_STAGES = 2;

  typedef struct packed {
    logic valid;
    logic mem_rd;
    logic reg_wr;
  } lu_ctl_t;

  localparam lu_ctl_t LU_CTL_NOP = '{valid: 1'b0, mem_rd: 1'b0, reg_wr: 1'b0};

endpackage

// File: rtl/lu_load_use_detect.sv
module lu_load_use_detect
  import lu_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int NSRC  = LU_NUM_SRC
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ex_mem_rd,
  input  logic [REG_W-1:0]           ex_dst,
  input  logic                       fd_valid,
  input  logic [NSRC-1:0][REG_W-1:0] fd_src,
  output logic [NSRC-1:0]            src_hit,
  output logic                       hazard
);

  // A producer clashes with a consumer operand when it is a load into a
  // real (nonzero) register that the operand names.
  function automatic logic load_clash(input logic             is_load,
                                      input logic [REG_W-1:0] target,
                                      input logic [REG_W-1:0] operand);
    return is_load && (target != '0) && (target == operand);
  endfunction

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_hit[g] = fd_valid && load_clash(ex_mem_rd, ex_dst, fd_src[g]);
  end

  assign hazard = |src_hit;

  // R2: a load into register 0 is never a producer
  a_r2_zero_target: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0) |-> !hazard);

  // R3: an empty decode slot or a non-load never stalls
  a_r3_no_consumer: assert property (@(posedge clk) disable iff (!rst_n)
    (!fd_valid || !ex_mem_rd) |-> !hazard);

endmodule

// File: rtl/lu_stall_ctrl.sv
module lu_stall_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hazard,
  output logic pc_we,
  output logic fd_we,
  output logic ctl_bubble
);

  // Freeze the front end and inject a no-op for the hazard cycle only.
  assign pc_we      = !hazard;
  assign fd_we      = !hazard;
  assign ctl_bubble = hazard;

  // R6: one stall per conflict, never two in a row
  a_r6_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |=> !hazard);

endmodule

// File: rtl/lu_pipe_stage.sv
module lu_pipe_stage
  import lu_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             squash,
  input  lu_ctl_t          d_ctl,
  input  logic [REG_W-1:0] d_dst,
  output lu_ctl_t          q_ctl,
  output logic [REG_W-1:0] q_dst
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_ctl <= LU_CTL_NOP;
      q_dst <= '0;
    end else if (squash) begin
      q_ctl <= LU_CTL_NOP;
      q_dst <= '0;
    end else if (en) begin
      q_ctl <= d_ctl;
      q_dst <= d_dst;
    end
  end

  // R5: a squashed stage carries zero control on the next cycle
  a_r5_bubble_zero: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (q_ctl == LU_CTL_NOP));

  // R4: a frozen stage keeps its contents
  a_r4_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !squash) |=> ($stable(q_ctl) && $stable(q_dst)));

endmodule

// File: rtl/lu_hazard_unit.sv
module lu_hazard_unit
  import lu_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             if_valid,
  input  logic             if_mem_rd,
  input  logic             if_reg_wr,
  input  logic [REG_W-1:0] if_dst,
  input  logic [REG_W-1:0] if_src_a,
  input  logic [REG_W-1:0] if_src_b,
  output logic             pc_we,
  output logic             fd_we,
  output logic             ctl_bubble,
  output logic             hazard,
  output logic             ex_valid,
  output logic             ex_mem_rd,
  output logic             ex_reg_wr,
  output logic [REG_W-1:0] ex_dst,
  output logic             wb_valid,
  output logic             wb_mem_rd,
  output logic             wb_reg_wr,
  output logic [REG_W-1:0] wb_dst
);

  localparam int NSRC  = LU_NUM_SRC;
  localparam int NTAIL = LU_TAIL_STAGES;

  // Fetch slot as seen by the front end.
  lu_ctl_t                   if_ctl;
  logic [NSRC-1:0][REG_W-1:0] if_src;
  assign if_ctl = '{valid: if_valid, mem_rd: if_mem_rd, reg_wr: if_reg_wr};
  assign if_src = {if_src_b, if_src_a};

  // Fetch/decode register: control, destination and operand numbers.
  lu_ctl_t                    fd_ctl;
  logic [REG_W-1:0]           fd_dst;
  logic [NSRC-1:0][REG_W-1:0] fd_src;

  lu_pipe_stage #(.REG_W(REG_W)) u_fd (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (fd_we),
    .squash (1'b0),
    .d_ctl  (if_ctl),
    .d_dst  (if_dst),
    .q_ctl  (fd_ctl),
    .q_dst  (fd_dst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     fd_src <= '0;
    else if (fd_we) fd_src <= if_src;
  end

  // Decode/execute register, squashed to a no-op on a stall.
  lu_ctl_t          ex_ctl;
  logic [REG_W-1:0] ex_dst_q;

  lu_pipe_stage #(.REG_W(REG_W)) u_ex (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (1'b1),
    .squash (ctl_bubble),
    .d_ctl  (fd_ctl),
    .d_dst  (fd_dst),
    .q_ctl  (ex_ctl),
    .q_dst  (ex_dst_q)
  );

  // Hazard detection on decode/execute load vs fetch/decode operands.
  logic [NSRC-1:0] src_hit;

  lu_load_use_detect #(.REG_W(REG_W), .NSRC(NSRC)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .ex_mem_rd (ex_ctl.mem_rd),
    .ex_dst    (ex_dst_q),
    .fd_valid  (fd_ctl.valid),
    .fd_src    (fd_src),
    .src_hit   (src_hit),
    .hazard    (hazard)
  );

  lu_stall_ctrl u_stall (
    .clk        (clk),
    .rst_n      (rst_n),
    .hazard     (hazard),
    .pc_we      (pc_we),
    .fd_we      (fd_we),
    .ctl_bubble (ctl_bubble)
  );

  // Execute/memory and memory/writeback registers.
  lu_ctl_t          tail_ctl [NTAIL+1];
  logic [REG_W-1:0] tail_dst [NTAIL+1];
  assign tail_ctl[0] = ex_ctl;
  assign tail_dst[0] = ex_dst_q;

  for (genvar s = 0; s < NTAIL; s++) begin : g_tail
    lu_pipe_stage #(.REG_W(REG_W)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (1'b1),
      .squash (1'b0),
      .d_ctl  (tail_ctl[s]),
      .d_dst  (tail_dst[s]),
      .q_ctl  (tail_ctl[s+1]),
      .q_dst  (tail_dst[s+1])
    );
  end

  assign ex_valid  = ex_ctl.valid;
  assign ex_mem_rd = ex_ctl.mem_rd;
  assign ex_reg_wr = ex_ctl.reg_wr;
  assign ex_dst    = ex_dst_q;
  assign wb_valid  = tail_ctl[NTAIL].valid;
  assign wb_mem_rd = tail_ctl[NTAIL].mem_rd;
  assign wb_reg_wr = tail_ctl[NTAIL].reg_wr;
  assign wb_dst    = tail_dst[NTAIL];

  // R4: both enables drop in a hazard cycle
  a_r4_front_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> (!pc_we && !fd_we));

  // R4: operand numbers survive a freeze so the consumer decodes again
  a_r4_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    !fd_we |=> (fd_src == $past(fd_src)));

  // R5: the bubble reaches execute as an empty slot
  a_r5_ex_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_bubble |=> (!ex_valid && !ex_mem_rd && !ex_reg_wr));

endmodule

// File: tb/tb_lu_hazard_unit.sv
module tb_lu_hazard_unit;

  localparam int RW   = 5;
  localparam int MAXN = 32;
  localparam int MAXC = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          if_valid, if_mem_rd, if_reg_wr;
  logic [RW-1:0] if_dst, if_src_a, if_src_b;
  logic          pc_we, fd_we, ctl_bubble, hazard;
  logic          ex_valid, ex_mem_rd, ex_reg_wr;
  logic [RW-1:0] ex_dst;
  logic          wb_valid, wb_mem_rd, wb_reg_wr;
  logic [RW-1:0] wb_dst;

  lu_hazard_unit #(.REG_W(RW)) dut (
    .clk(clk), .rst_n(rst_n),
    .if_valid(if_valid), .if_mem_rd(if_mem_rd), .if_reg_wr(if_reg_wr),
    .if_dst(if_dst), .if_src_a(if_src_a), .if_src_b(if_src_b),
    .pc_we(pc_we), .fd_we(fd_we), .ctl_bubble(ctl_bubble), .hazard(hazard),
    .ex_valid(ex_valid), .ex_mem_rd(ex_mem_rd), .ex_reg_wr(ex_reg_wr), .ex_dst(ex_dst),
    .wb_valid(wb_valid), .wb_mem_rd(wb_mem_rd), .wb_reg_wr(wb_reg_wr), .wb_dst(wb_dst)
  );

  int checks = 0;
  int errors = 0;

  logic          p_ld [MAXN];
  logic [RW-1:0] p_dst[MAXN];
  logic [RW-1:0] p_sa [MAXN];
  logic [RW-1:0] p_sb [MAXN];
  int            n_prog;
  bit            exp_hz[MAXC];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Adjacent pair (i, i+1) needs a stall per the requirement text.
  function automatic bit pair_needs_stall(input int i);
    if (i + 1 >= n_prog) return 1'b0;
    if (!p_ld[i] || p_dst[i] == '0) return 1'b0;
    return (p_dst[i] == p_sa[i+1]) || (p_dst[i] == p_sb[i+1]);
  endfunction

  // Fill exp_hz from the program and return the stall count.
  function automatic int plan_stalls();
    int s = 0;
    for (int c = 0; c < MAXC; c++) exp_hz[c] = 1'b0;
    for (int i = 0; i < n_prog; i++) begin
      if (pair_needs_stall(i)) begin
        exp_hz[i + s + 2] = 1'b1;   // load sits in execute two cycles after it is fetched
        s++;
      end
    end
    return s;
  endfunction

  task automatic set_ins(input int i, input bit ld, input int d, input int a, input int b);
    p_ld[i] = ld; p_dst[i] = RW'(d); p_sa[i] = RW'(a); p_sb[i] = RW'(b);
  endtask

  task automatic drive_idle();
    if_valid = 0; if_mem_rd = 0; if_reg_wr = 0;
    if_dst = '0; if_src_a = '0; if_src_b = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive_idle();
    repeat (2) @(posedge clk);
    #1;
    check(pc_we && fd_we, "R7", "enables in reset", {pc_we, fd_we}, 3);
    check(!ctl_bubble && !hazard, "R7", "bubble/hazard in reset", {ctl_bubble, hazard}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!ex_valid && !wb_valid, "R7", "stages empty after reset", {ex_valid, wb_valid}, 0);
  endtask

  task automatic run_prog(input string name);
    int s_exp, pc, ret, last, seen;
    do_reset();
    s_exp = plan_stalls();
    pc = 0; ret = 0; last = -1; seen = 0;
    for (int c = 0; c < n_prog + s_exp + 8; c++) begin
      if (pc < n_prog) begin
        if_valid = 1; if_mem_rd = p_ld[pc]; if_reg_wr = 1;
        if_dst = p_dst[pc]; if_src_a = p_sa[pc]; if_src_b = p_sb[pc];
      end else begin
        drive_idle();
      end
      #1;
      if (hazard) seen++;
      if (exp_hz[c])
        check(hazard == 1'b1, "R1", {name, " stall missing"}, hazard, 1);
      else
        check(hazard == 1'b0, "R3", {name, " unexpected stall"}, hazard, 0);
      check(pc_we == !exp_hz[c] && fd_we == !exp_hz[c], "R4", {name, " enables"},
            {pc_we, fd_we}, exp_hz[c] ? 0 : 3);
      check(ctl_bubble == exp_hz[c], "R5", {name, " bubble"}, ctl_bubble, exp_hz[c]);
      if (c > 0 && exp_hz[c-1])
        check(!ex_valid && !ex_mem_rd && !ex_reg_wr, "R5", {name, " execute not empty"},
              {ex_valid, ex_mem_rd, ex_reg_wr}, 0);
      if (wb_valid) begin
        if (ret < n_prog)
          check(wb_dst == p_dst[ret], "R8", {name, " retire order"}, wb_dst, p_dst[ret]);
        ret++;
        last = c;
      end
      if (pc_we && pc < n_prog) pc++;
      @(negedge clk);
    end
    check(seen == s_exp, "R6", {name, " stall count"}, seen, s_exp);
    check(ret == n_prog, "R8", {name, " retired count"}, ret, n_prog);
    check(last == n_prog + s_exp + 3, "R8", {name, " last retire cycle"}, last, n_prog + s_exp + 3);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2021));
    drive_idle();

    // R3: two independent loads, then a use two slots after the load
    n_prog = 4;
    set_ins(0, 1, 1, 3, 3); set_ins(1, 1, 2, 3, 3);
    set_ins(2, 0, 4, 5, 6); set_ins(3, 0, 7, 1, 2);
    run_prog("R3 independent loads");

    // R1: load feeds the address operand (source A) of a store
    n_prog = 2;
    set_ins(0, 1, 1, 3, 0); set_ins(1, 0, 0, 1, 5);
    run_prog("R1 source A");

    // R1: load feeds source B
    n_prog = 3;
    set_ins(0, 1, 2, 4, 4); set_ins(1, 0, 6, 3, 2); set_ins(2, 0, 7, 8, 9);
    run_prog("R1 source B");

    // R2: load into register 0 followed by a reader of register 0
    n_prog = 2;
    set_ins(0, 1, 0, 3, 3); set_ins(1, 0, 5, 0, 0);
    run_prog("R2 zero target");

    // R6: chained loads, two separate single-cycle stalls
    n_prog = 3;
    set_ins(0, 1, 1, 3, 3); set_ins(1, 1, 2, 1, 1); set_ins(2, 0, 4, 2, 2);
    run_prog("R6 chain");

    // Random sequences over a small register set (R1, R2, R3, R6, R8)
    for (int r = 0; r < 6; r++) begin
      n_prog = 24;
      for (int i = 0; i < n_prog; i++)
        set_ins(i, bit'($urandom % 2), int'($urandom % 4), int'($urandom % 4), int'($urandom % 4));
      run_prog($sformatf("random %0d", r));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule